// File: doc/BRIEF.md
# Power-Down Mode Controller

This block sits beside a processor core and decides what happens when the core executes its sleep instruction. Three control bits select the target: the standby-select bit, the low-speed bit and the watchdog clock-select bit. From them it picks one of two stop modes. In light sleep only the core clock is gated and the peripherals keep running. In deep standby the core clock, the peripheral clocks and the oscillator are all switched off. If the bits name neither mode, the block flags the request as unsupported and the core keeps running.

Each mode has its own set of wake-up sources. Any qualified interrupt source ends light sleep. Deep standby ends only on NMI or on a qualified external source, which covers the IRQ, key-input, wake-up and PS/2 lines. On a standby wake the oscillator is restarted first. The block then counts a programmable power-of-two settling time before it lets the core run again. Every exit ends with exactly one wake pulse, which starts interrupt exception handling. The active-low reset pin overrides everything: it forces the reset state at once, and a one-cycle pulse marks the start of reset exception handling after release.

States: `ST_RESET`, `ST_RST_EXIT`, `ST_ACTIVE`, `ST_SLEEP`, `ST_SLP_WAKE`, `ST_STANDBY`, `ST_SETTLE`, `ST_STB_WAKE`. Transitions:
- pin low from any state → `ST_RESET`
- `ST_RESET` → `ST_RST_EXIT` on the first edge after release, then → `ST_ACTIVE`
- `ST_ACTIVE` → `ST_SLEEP` or `ST_STANDBY` on a supported sleep request
- `ST_SLEEP` → `ST_SLP_WAKE` → `ST_ACTIVE`
- `ST_STANDBY` → `ST_SETTLE` → (count done) `ST_STB_WAKE` → `ST_ACTIVE`

Top module: `pd_power_ctrl`

## Requirements
- R1: A sleep strobe in the active mode with standby_sel=0 and lowspeed_sel=0 (watchdog_clk_sel ignored) puts mode=01 after the next edge. In that mode cpu_clk_en=0, per_clk_en=1 and osc_en=1.
- R2: A sleep strobe with standby_sel=1, lowspeed_sel=0 and watchdog_clk_sel=0 puts mode=10 after the next edge. In that mode cpu_clk_en, per_clk_en and osc_en are all 0.
- R3: A sleep strobe with lowspeed_sel=1, or with standby_sel=1 and watchdog_clk_sel=1, raises unsup_flag for exactly the one cycle after the strobe. Mode stays 00 and cpu_clk_en stays 1.
- R4: Source i is live when irq_req[i]=1, irq_en[i]=1 and irq_mask[i]=0. In light sleep any live source, of any index, wakes the core, and so does nmi, which has no mask. A requesting source that is disabled or masked leaves the block asleep.
- R5: In deep standby only nmi and live sources with index below N_EXT wake the core. A live source with index N_EXT or above (internal peripherals) leaves mode=10 and the oscillator off.
- R6: In deep standby an external source that is requesting but disabled or masked does not wake the core.
- R7: When a standby wake request is seen, osc_en rises one edge later and the core clock stays off for exactly 2^(SETTLE_BASE+s) cycles. Here s is settle_sel as sampled at the sleep strobe, and later changes to settle_sel have no effect.
- R8: Each exit gives exactly one wake_pulse, one cycle wide, during which cpu_clk_en=1. Sleep exit raises it one edge after the wake request; standby exit raises it 1+2^(SETTLE_BASE+s) edges after the request. Mode reads 00 in the next cycle.
- R9: While rst_pin_n=0, mode reads 11 at once, even from sleep or standby, with cpu_clk_en=0, per_clk_en=0 and osc_en=1. After release, rst_exc_start pulses for one cycle on the first edge, and mode becomes 00 on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous entry |
| sleep_req | input | 1 | One-cycle strobe: sleep instruction executed |
| standby_sel | input | 1 | Standby-select control bit |
| lowspeed_sel | input | 1 | Low-speed control bit |
| watchdog_clk_sel | input | 1 | Watchdog clock-select bit |
| settle_sel | input | 3 | Oscillator settling-time select |
| nmi | input | 1 | Non-maskable interrupt request |
| irq_req | input | N_SRC | Per-source interrupt requests, low N_EXT bits external |
| irq_en | input | N_SRC | Per-source enables |
| irq_mask | input | N_SRC | Per-source CPU masks |
| cpu_clk_en | output | 1 | Core clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| osc_en | output | 1 | Oscillator enable |
| wake_pulse | output | 1 | Start interrupt exception handling |
| rst_exc_start | output | 1 | Start reset exception handling |
| unsup_flag | output | 1 | Unsupported sleep request seen |
| mode | output | 2 | 00 active, 01 sleep, 10 standby, 11 reset |

## Verification
Sleep entry is driven with every combination of the three control bits, so that light sleep, deep standby and the unsupported cases are told apart by mode and unsup_flag. Wake inputs are tried one source at a time: an external and an internal live source, a disabled source, a masked source, and NMI with all sources masked. This shows which qualification term each mode honours. Standby exits with several settling selects and an exact edge count, so an off-by-one or a wrong table entry in the counter shows up. A select changed after entry shows whether the field is sampled at the strobe.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        MODE_ACT = 2'b00,
        MODE_SLP = 2'b01,
        MODE_STB = 2'b10,
        MODE_RST = 2'b11
    } pd_mode_e;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_RST_EXIT,
        ST_ACTIVE,
        ST_SLEEP,
        ST_SLP_WAKE,
        ST_STANDBY,
        ST_SETTLE,
        ST_STB_WAKE
    } pd_state_e;

    typedef enum logic [1:0] {
        REQ_SLEEP,
        REQ_STBY,
        REQ_BAD
    } pd_req_e;

endpackage

// File: rtl/pd_wake_qual.sv
module pd_wake_qual #(
    parameter int N_SRC = 16,
    parameter int N_EXT = 10
) (
    input  logic             nmi,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] irq_en,
    input  logic [N_SRC-1:0] irq_mask,
    output logic             sleep_wake,
    output logic             stby_wake
);

    logic [N_SRC-1:0] live;
    logic [N_SRC-1:0] ext_live;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign live[i] = irq_req[i] & irq_en[i] & ~irq_mask[i];
        if (i < N_EXT) begin : g_ext
            assign ext_live[i] = live[i];
        end else begin : g_int
            assign ext_live[i] = 1'b0;
        end
    end

    assign sleep_wake = nmi | (|live);
    assign stby_wake  = nmi | (|ext_live);

endmodule

// File: rtl/pd_settle_timer.sv
module pd_settle_timer #(
    parameter int SETTLE_BASE = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] sel_in,
    input  logic       run,
    output logic       done
);

    localparam int CNT_W = SETTLE_BASE + 8;

    logic [2:0]       sel_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;

    assign lim_m1 = (CNT_W'(1) << (CNT_W'(SETTLE_BASE) + CNT_W'(sel_q))) - CNT_W'(1);
    assign done   = run && (cnt == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 3'd0;
        end else if (load) begin
            sel_q <= sel_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= lim_m1)); // R7
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(sel_q)); // R7

endmodule

// File: rtl/pd_mode_fsm.sv
module pd_mode_fsm
    import pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       standby_sel,
    input  logic       lowspeed_sel,
    input  logic       watchdog_clk_sel,
    input  logic       sleep_wake,
    input  logic       stby_wake,
    input  logic       settle_done,
    output logic       settle_load,
    output logic       settle_run,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       wake_pulse,
    output logic       rst_exc_start,
    output logic       unsup_flag,
    output logic [1:0] mode
);

    pd_state_e cur, nxt;
    pd_req_e   kind;
    pd_mode_e  mode_e;

    always_comb begin
        if (lowspeed_sel) begin
            kind = REQ_BAD;
        end else if (!standby_sel) begin
            kind = REQ_SLEEP;
        end else if (!watchdog_clk_sel) begin
            kind = REQ_STBY;
        end else begin
            kind = REQ_BAD;
        end
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_RESET:    nxt = ST_RST_EXIT;
            ST_RST_EXIT: nxt = ST_ACTIVE;
            ST_ACTIVE: begin
                if (sleep_req && kind == REQ_SLEEP) begin
                    nxt = ST_SLEEP;
                end else if (sleep_req && kind == REQ_STBY) begin
                    nxt = ST_STANDBY;
                end
            end
            ST_SLEEP:    if (sleep_wake) nxt = ST_SLP_WAKE;
            ST_SLP_WAKE: nxt = ST_ACTIVE;
            ST_STANDBY:  if (stby_wake) nxt = ST_SETTLE;
            ST_SETTLE:   if (settle_done) nxt = ST_STB_WAKE;
            ST_STB_WAKE: nxt = ST_ACTIVE;
            default:     nxt = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= ST_RESET;
        end else begin
            cur <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unsup_flag <= 1'b0;
        end else begin
            unsup_flag <= (cur == ST_ACTIVE) && sleep_req && (kind == REQ_BAD);
        end
    end

    assign settle_load = (cur == ST_ACTIVE) && sleep_req && (kind == REQ_STBY);

    always_comb begin
        cpu_clk_en    = 1'b0;
        per_clk_en    = 1'b0;
        osc_en        = 1'b1;
        wake_pulse    = 1'b0;
        rst_exc_start = 1'b0;
        settle_run    = 1'b0;
        mode_e        = MODE_RST;
        unique case (cur)
            ST_RESET: begin
                mode_e = MODE_RST;
            end
            ST_RST_EXIT: begin
                rst_exc_start = 1'b1;
                mode_e        = MODE_RST;
            end
            ST_ACTIVE: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
                mode_e     = MODE_ACT;
            end
            ST_SLEEP: begin
                per_clk_en = 1'b1;
                mode_e     = MODE_SLP;
            end
            ST_SLP_WAKE: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
                wake_pulse = 1'b1;
                mode_e     = MODE_SLP;
            end
            ST_STANDBY: begin
                osc_en = 1'b0;
                mode_e = MODE_STB;
            end
            ST_SETTLE: begin
                settle_run = 1'b1;
                mode_e     = MODE_STB;
            end
            ST_STB_WAKE: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
                wake_pulse = 1'b1;
                mode_e     = MODE_STB;
            end
            default: begin
                mode_e = MODE_RST;
            end
        endcase
    end

    assign mode = mode_e;

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ACT && sleep_req && !standby_sel && !lowspeed_sel)
        |=> (mode == MODE_SLP && !cpu_clk_en && per_clk_en)); // R1
    AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ACT && sleep_req && standby_sel && !lowspeed_sel && !watchdog_clk_sel)
        |=> (mode == MODE_STB && !osc_en)); // R2
    AST_UNSUP_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ACT && sleep_req && lowspeed_sel)
        |=> (mode == MODE_ACT && unsup_flag && cpu_clk_en)); // R3
    AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_STANDBY && !stby_wake) |=> (cur == ST_STANDBY)); // R5
    AST_OSC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_STANDBY && stby_wake) |=> (osc_en && !cpu_clk_en)); // R7
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> (!wake_pulse && mode == MODE_ACT)); // R8
    AST_RST_EXIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_exc_start |=> (!rst_exc_start && mode == MODE_ACT)); // R9

endmodule

// File: rtl/pd_power_ctrl.sv
module pd_power_ctrl #(
    parameter int N_SRC       = 16,
    parameter int N_EXT       = 10,
    parameter int SETTLE_BASE = 6
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             sleep_req,
    input  logic             standby_sel,
    input  logic             lowspeed_sel,
    input  logic             watchdog_clk_sel,
    input  logic [2:0]       settle_sel,
    input  logic             nmi,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] irq_en,
    input  logic [N_SRC-1:0] irq_mask,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             wake_pulse,
    output logic             rst_exc_start,
    output logic             unsup_flag,
    output logic [1:0]       mode
);

    logic sleep_wake;
    logic stby_wake;
    logic settle_load;
    logic settle_run;
    logic settle_done;

    initial begin
        AST_EXT_FITS: assert (N_EXT <= N_SRC && N_EXT >= 0); // R5
    end

    pd_wake_qual #(
        .N_SRC (N_SRC),
        .N_EXT (N_EXT)
    ) i_wake_qual (
        .nmi        (nmi),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .irq_mask   (irq_mask),
        .sleep_wake (sleep_wake),
        .stby_wake  (stby_wake)
    );

    pd_settle_timer #(
        .SETTLE_BASE (SETTLE_BASE)
    ) i_settle_timer (
        .clk    (clk),
        .rst_n  (rst_pin_n),
        .load   (settle_load),
        .sel_in (settle_sel),
        .run    (settle_run),
        .done   (settle_done)
    );

    pd_mode_fsm i_mode_fsm (
        .clk              (clk),
        .rst_n            (rst_pin_n),
        .sleep_req        (sleep_req),
        .standby_sel      (standby_sel),
        .lowspeed_sel     (lowspeed_sel),
        .watchdog_clk_sel (watchdog_clk_sel),
        .sleep_wake       (sleep_wake),
        .stby_wake        (stby_wake),
        .settle_done      (settle_done),
        .settle_load      (settle_load),
        .settle_run       (settle_run),
        .cpu_clk_en       (cpu_clk_en),
        .per_clk_en       (per_clk_en),
        .osc_en           (osc_en),
        .wake_pulse       (wake_pulse),
        .rst_exc_start    (rst_exc_start),
        .unsup_flag       (unsup_flag),
        .mode             (mode)
    );

endmodule

// File: tb/test_pd_power_ctrl.sv
`timescale 1ns/1ps
module test_pd_power_ctrl;

    localparam int NS = 8;
    localparam int NE = 5;
    localparam int SB = 2;
    localparam int VW = 34;
    localparam int NV = 15;

    logic clk = 1'b0;
    logic rst_pin_n = 1'b0;
    logic sleep_req = 1'b0, standby_sel = 1'b0, lowspeed_sel = 1'b0, watchdog_clk_sel = 1'b0;
    logic [2:0] settle_sel = 3'd0;
    logic nmi = 1'b0;
    logic [NS-1:0] irq_req = '0, irq_en = '0, irq_mask = '0;
    logic cpu_clk_en, per_clk_en, osc_en, wake_pulse, rst_exc_start, unsup_flag;
    logic [1:0] mode;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pd_power_ctrl #(.N_SRC(NS), .N_EXT(NE), .SETTLE_BASE(SB)) i_pd_power_ctrl (
        .clk(clk), .rst_pin_n(rst_pin_n), .sleep_req(sleep_req),
        .standby_sel(standby_sel), .lowspeed_sel(lowspeed_sel),
        .watchdog_clk_sel(watchdog_clk_sel), .settle_sel(settle_sel), .nmi(nmi),
        .irq_req(irq_req), .irq_en(irq_en), .irq_mask(irq_mask),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .wake_pulse(wake_pulse), .rst_exc_start(rst_exc_start),
        .unsup_flag(unsup_flag), .mode(mode)
    );

    // {ctl(stby,lowspd,wdt), sel, req, en, msk, nmi, exp_mode, exp_wake}
    localparam logic [VW-1:0] VECS [NV] = '{
        {3'b001, 3'd0, 8'h01, 8'h01, 8'h00, 1'b0, 2'd1, 1'b1}, // R1 R4 ext live
        {3'b000, 3'd0, 8'h40, 8'h40, 8'h00, 1'b0, 2'd1, 1'b1}, // R4 internal live
        {3'b000, 3'd0, 8'h04, 8'h00, 8'h00, 1'b0, 2'd1, 1'b0}, // R4 disabled
        {3'b000, 3'd0, 8'h08, 8'h08, 8'h08, 1'b0, 2'd1, 1'b0}, // R4 masked
        {3'b000, 3'd0, 8'hFF, 8'hFF, 8'hFF, 1'b1, 2'd1, 1'b1}, // R4 nmi past mask
        {3'b100, 3'd0, 8'h02, 8'h02, 8'h00, 1'b0, 2'd2, 1'b1}, // R2 R7 sel 0
        {3'b100, 3'd3, 8'h10, 8'h10, 8'h00, 1'b0, 2'd2, 1'b1}, // R7 sel 3
        {3'b100, 3'd0, 8'h80, 8'h80, 8'h00, 1'b0, 2'd2, 1'b0}, // R5 internal
        {3'b100, 3'd0, 8'h20, 8'h20, 8'h00, 1'b0, 2'd2, 1'b0}, // R5 first internal
        {3'b100, 3'd0, 8'h01, 8'h01, 8'h01, 1'b0, 2'd2, 1'b0}, // R6 masked
        {3'b100, 3'd0, 8'h04, 8'h00, 8'h00, 1'b0, 2'd2, 1'b0}, // R6 disabled
        {3'b100, 3'd7, 8'h00, 8'h00, 8'h00, 1'b1, 2'd2, 1'b1}, // R7 sel 7 by nmi
        {3'b010, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0}, // R3 lowspeed
        {3'b101, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0}, // R3 stby+wdt
        {3'b110, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0}  // R3 both
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic strobe_sleep(input logic [2:0] ctl, input logic [2:0] sel);
        @(negedge clk);
        {standby_sel, lowspeed_sel, watchdog_clk_sel} = ctl;
        settle_sel = sel;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    // returns edges from the current negedge until wake_pulse is seen
    task automatic wait_wake(output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while (!wake_pulse && n < 3000);
    endtask

    task automatic clear_src();
        nmi = 1'b0; irq_req = '0; irq_en = '0; irq_mask = '0;
    endtask

    initial begin
        int n;
        int lim;
        // R9 reset state
        #1;
        chk(mode == 2'd3 && !cpu_clk_en && !per_clk_en && osc_en, "R9", "reset outputs",
            {mode, cpu_clk_en, per_clk_en, osc_en}, 'b11001);
        repeat (3) @(negedge clk);
        rst_pin_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(rst_exc_start && mode == 2'd3, "R9", "reset exit pulse", {rst_exc_start, mode}, 'b111);
        @(posedge clk); @(negedge clk);
        chk(!rst_exc_start && mode == 2'd0 && cpu_clk_en, "R9", "active after reset",
            {rst_exc_start, mode, cpu_clk_en}, 'b0001);

        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] w;
            logic [1:0] xm;
            w = VECS[v];
            xm = w[2:1];
            strobe_sleep(w[33:31], w[30:28]);
            chk(mode == xm, "R1/R2/R3", $sformatf("vec %0d mode", v), mode, xm);
            if (xm == 2'd0) begin
                chk(unsup_flag && cpu_clk_en, "R3", $sformatf("vec %0d unsup", v),
                    {unsup_flag, cpu_clk_en}, 'b11);
                @(negedge clk);
                chk(!unsup_flag, "R3", "flag one cycle", unsup_flag, 0);
            end else begin
                if (xm == 2'd1)
                    chk(!cpu_clk_en && per_clk_en && osc_en, "R1", "sleep gates",
                        {cpu_clk_en, per_clk_en, osc_en}, 'b011);
                else
                    chk(!cpu_clk_en && !per_clk_en && !osc_en, "R2", "standby gates",
                        {cpu_clk_en, per_clk_en, osc_en}, 'b000);
                irq_req = w[27:20]; irq_en = w[19:12]; irq_mask = w[11:4]; nmi = w[3];
                lim = 1 << (SB + int'(w[30:28]));
                if (w[0]) begin
                    @(posedge clk); @(negedge clk);
                    if (xm == 2'd2) begin
                        chk(osc_en && !cpu_clk_en && !wake_pulse, "R7", "osc first",
                            {osc_en, cpu_clk_en, wake_pulse}, 'b100);
                        wait_wake(n);
                        n = n + 1;
                        chk(n == 1 + lim, "R7", $sformatf("vec %0d settle edges", v), n, 1 + lim);
                    end else begin
                        chk(wake_pulse && cpu_clk_en, "R4", $sformatf("vec %0d sleep wake", v),
                            {wake_pulse, cpu_clk_en}, 'b11);
                    end
                    clear_src();
                    @(negedge clk);
                    chk(!wake_pulse && mode == 2'd0, "R8", "single pulse then active",
                        {wake_pulse, mode}, 'b000);
                end else begin
                    int seen;
                    seen = 0;
                    for (int k = 0; k < 20; k++) begin
                        @(negedge clk);
                        if (wake_pulse || osc_en != (xm == 2'd1)) seen++;
                    end
                    chk(seen == 0 && mode == xm, (xm == 2'd1) ? "R4" : "R5/R6",
                        $sformatf("vec %0d no wake", v), seen, 0);
                    clear_src();
                    nmi = 1'b1;
                    wait_wake(n);
                    nmi = 1'b0;
                    @(negedge clk);
                    chk(mode == 2'd0, "R8", "nmi recovery", mode, 0);
                end
            end
        end

        // R7: select is sampled at the strobe, later change has no effect
        strobe_sleep(3'b100, 3'd1);
        settle_sel = 3'd7;
        irq_req = 8'h01; irq_en = 8'h01;
        wait_wake(n);
        chk(n == 1 + 8, "R7", "select sampled at strobe", n, 9);
        clear_src();
        @(negedge clk);

        // R9: reset from sleep, asynchronous
        strobe_sleep(3'b000, 3'd0);
        rst_pin_n = 1'b0;
        #1;
        chk(mode == 2'd3 && !per_clk_en, "R9", "reset from sleep", {mode, per_clk_en}, 'b110);
        @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9: reset from standby
        strobe_sleep(3'b100, 3'd0);
        rst_pin_n = 1'b0;
        #1;
        chk(mode == 2'd3 && osc_en, "R9", "reset from standby", {mode, osc_en}, 'b111);
        @(negedge clk);
        rst_pin_n = 1'b1;
        @(negedge clk);
        chk(rst_exc_start, "R9", "exit pulse after standby reset", rst_exc_start, 1);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule